// File: doc/BRIEF.md
# Bandwidth Throttle Value Quantizer

This block turns a requested delay (throttle) value for one class of service into the value that the bandwidth throttling hardware really applies. Software hands it a class index and a raw request. The block first limits the request to a configured maximum. It then rounds the result down by one of two rules, chosen by a mode input, and writes the rounded value into a per-class table. Other logic reads that table through a one-cycle read port.

There are two rounding rules. In linear mode the request is rounded down to a whole multiple of a precision step, and the step is 100 minus the configured maximum. In power-of-two mode the request is rounded down to zero or to the highest power of two that does not exceed it. Linear rounding uses repeated subtraction over several cycles. Power-of-two rounding uses a leading-one detector and takes a single cycle. A busy/done handshake reports when a request has been taken and when its result has been written.

Top module: `thr_quantizer`

## Requirements
- R1: After reset every class in the table reads 0 (no delay), class 0 included, and `busy` and `done` are 0.
- R2: A request above `cfg_max` is clamped to `cfg_max` before rounding, and `done_clamp` is 1 with that result. A request at or below `cfg_max` gives `done_clamp` = 0.
- R3: With `cfg_nonlin` = 0 the step is 100 − `cfg_max` when `cfg_max` ≤ 99, and 1 when `cfg_max` ≥ 100. The result is the largest multiple of the step that does not exceed the clamped request (for example 12 with a step of 10 gives 10).
- R4: In linear mode, `done` rises exactly q+1 clock edges after the edge that accepts the request, where q = floor(clamped / step).
- R5: With `cfg_nonlin` = 1 the result is 0 for a clamped value of 0, and otherwise the highest power of two not above the clamped value (12 gives 8). `done` rises on the edge after the accepting edge.
- R6: On the edge that raises `done`, `done_val` is placed in the table entry of the accepted class. `rd_val` shows the entry selected by `rd_cls` one clock edge after `rd_cls` is presented.
- R7: A request is accepted only on an edge where `req_valid` = 1 and `busy` = 0. A request presented while `busy` = 1 is dropped and changes no table entry.
- R8: `done` is high for exactly one cycle per accepted request, and `busy` is 0 whenever `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_nonlin | input | 1 | Rounding mode: 0 linear, 1 power of two; sampled at acceptance |
| cfg_max | input | VAL_W | Largest allowed throttle value; sampled at acceptance |
| req_valid | input | 1 | Request strobe |
| req_cls | input | CLS_W | Class index of the request |
| req_val | input | VAL_W | Raw requested throttle value |
| busy | output | 1 | A request is being rounded |
| done | output | 1 | One-cycle pulse when a result is written |
| done_val | output | VAL_W | Rounded value written, valid with `done` |
| done_clamp | output | 1 | The request exceeded `cfg_max`, valid with `done` |
| rd_cls | input | CLS_W | Class index to read |
| rd_val | output | VAL_W | Stored value of class `rd_cls`, registered |

## Verification
The bench uses the default values: eight classes and a 7-bit value. With these values every request from 0 to 127 can be reached, so the maximum of 100 and above (step 1, the longest subtraction run) and a clamp of the top code 127 can both be driven. Several maxima give steps of 10, 25 and 1, which exercise the rounding and the q+1 latency rule. The class count lets one class be written while a dropped request targets another class, and the bench then reads that class back.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int unsigned PCT_FULL = 100;

  // Limit a request to the configured maximum.
  function automatic logic [6:0] f_clamp(input logic [6:0] v, input logic [6:0] mx);
    return (v > mx) ? mx : v;
  endfunction

  // Linear precision step; a maximum of 100 or more degenerates to step 1.
  function automatic logic [6:0] f_step(input logic [6:0] mx);
    if (32'(mx) >= PCT_FULL) return 7'd1;
    return 7'(PCT_FULL) - mx;
  endfunction
endpackage

// File: rtl/thr_lod.sv
module thr_lod #(
  parameter int VAL_W = 7
) (
  input  logic [VAL_W-1:0] val,
  output logic [VAL_W-1:0] pow2
);
  logic [VAL_W-1:0] hi;

  generate
    for (genvar i = 0; i < VAL_W; i++) begin : g_bit
      if (i == VAL_W - 1) begin : g_top
        assign hi[i] = val[i];
      end else begin : g_low
        assign hi[i] = val[i] & ~(|val[VAL_W-1:i+1]);
      end
    end
  endgenerate

  assign pow2 = hi;

  // R5: the detector marks at most one bit
  always_comb begin
    a_r5_lod_onehot: assert ($onehot0(hi)) else $error("leading-one not one-hot");
  end
endmodule

// File: rtl/thr_lin_seq.sv
module thr_lin_seq #(
  parameter int VAL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VAL_W-1:0] val,
  input  logic [VAL_W-1:0] step,
  output logic             busy,
  output logic             fin,
  output logic [VAL_W-1:0] result
);
  logic             busy_q;
  logic [VAL_W-1:0] val_q, rem_q, step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      val_q  <= '0;
      rem_q  <= '0;
      step_q <= VAL_W'(1);
    end else if (start) begin
      busy_q <= 1'b1;
      val_q  <= val;
      rem_q  <= val;
      step_q <= step;
    end else if (fin) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      rem_q <= rem_q - step_q;
    end
  end

  assign fin    = busy_q && (rem_q < step_q);
  assign busy   = busy_q;
  assign result = val_q - rem_q;

  // R4: every non-final cycle strictly shrinks the remainder
  a_r4_rem_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !fin |=> rem_q < $past(rem_q));

  // R7: a new run never starts over a running one
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
endmodule

// File: rtl/thr_store.sv
module thr_store #(
  parameter int NUM_CLS = 8,
  parameter int VAL_W   = 7,
  localparam int CLS_W  = $clog2(NUM_CLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CLS_W-1:0] wr_cls,
  input  logic [VAL_W-1:0] wr_data,
  input  logic [CLS_W-1:0] rd_cls,
  output logic [VAL_W-1:0] rd_val
);
  logic [VAL_W-1:0] tbl [NUM_CLS];
  logic [VAL_W-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CLS; i++) tbl[i] <= '0;
      rd_q <= '0;
    end else begin
      if (wr_en) tbl[wr_cls] <= wr_data;
      rd_q <= tbl[rd_cls];
    end
  end

  assign rd_val = rd_q;

  // R6: a write lands in the addressed entry
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tbl[$past(wr_cls)] == $past(wr_data));
endmodule

// File: rtl/thr_quantizer.sv
module thr_quantizer #(
  parameter int NUM_CLS = 8,
  parameter int VAL_W   = 7,
  localparam int CLS_W  = $clog2(NUM_CLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_nonlin,
  input  logic [VAL_W-1:0] cfg_max,
  input  logic             req_valid,
  input  logic [CLS_W-1:0] req_cls,
  input  logic [VAL_W-1:0] req_val,
  output logic             busy,
  output logic             done,
  output logic [VAL_W-1:0] done_val,
  output logic             done_clamp,
  input  logic [CLS_W-1:0] rd_cls,
  output logic [VAL_W-1:0] rd_val
);
  import thr_pkg::*;

  logic             accept, lin_start, seq_busy, seq_fin;
  logic [VAL_W-1:0] clamped, step, pow2, seq_res;
  logic             nl_pend, clamp_q;
  logic [VAL_W-1:0] nl_res;
  logic [CLS_W-1:0] cls_q;
  logic             wr_en;
  logic [VAL_W-1:0] wr_data;
  logic             done_q, done_clamp_q;
  logic [VAL_W-1:0] done_val_q;

  assign accept    = req_valid && !busy;
  assign clamped   = VAL_W'(f_clamp(7'(req_val), 7'(cfg_max)));
  assign step      = VAL_W'(f_step(7'(cfg_max)));
  assign lin_start = accept && !cfg_nonlin;

  thr_lod #(.VAL_W(VAL_W)) u_lod (.val(clamped), .pow2(pow2));

  thr_lin_seq #(.VAL_W(VAL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(lin_start), .val(clamped), .step(step),
    .busy(seq_busy), .fin(seq_fin), .result(seq_res));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nl_pend <= 1'b0;
      nl_res  <= '0;
      cls_q   <= '0;
      clamp_q <= 1'b0;
    end else begin
      nl_pend <= accept && cfg_nonlin;
      if (accept) begin
        nl_res  <= pow2;
        cls_q   <= req_cls;
        clamp_q <= req_val > cfg_max;
      end
    end
  end

  assign busy    = seq_busy || nl_pend;
  assign wr_en   = seq_fin || nl_pend;
  assign wr_data = nl_pend ? nl_res : seq_res;

  thr_store #(.NUM_CLS(NUM_CLS), .VAL_W(VAL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cls(cls_q), .wr_data(wr_data),
    .rd_cls(rd_cls), .rd_val(rd_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q       <= 1'b0;
      done_val_q   <= '0;
      done_clamp_q <= 1'b0;
    end else begin
      done_q <= wr_en;
      if (wr_en) begin
        done_val_q   <= wr_data;
        done_clamp_q <= clamp_q;
      end
    end
  end

  assign done       = done_q;
  assign done_val   = done_val_q;
  assign done_clamp = done_clamp_q;

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: nothing is running when a result is reported
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5: a power-of-two result follows its acceptance by one edge
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cfg_nonlin |=> wr_en && !seq_busy);

  // R2: a clamped result never exceeds the maximum seen at acceptance
  a_r2_clamp_bound: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> clamped <= cfg_max);
endmodule

// File: tb/sim_thr_quantizer.sv
module sim_thr_quantizer;
  localparam int CLK_PERIOD = 10;
  localparam int NCLS = 8;
  localparam int VW   = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_nonlin = 1'b0;
  logic [VW-1:0] cfg_max = '0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_cls = '0;
  logic [VW-1:0] req_val = '0;
  logic          busy, done, done_clamp;
  logic [VW-1:0] done_val, rd_val;
  logic [2:0]    rd_cls = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thr_quantizer #(.NUM_CLS(NCLS), .VAL_W(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_nonlin(cfg_nonlin), .cfg_max(cfg_max),
    .req_valid(req_valid), .req_cls(req_cls), .req_val(req_val),
    .busy(busy), .done(done), .done_val(done_val), .done_clamp(done_clamp),
    .rd_cls(rd_cls), .rd_val(rd_val));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampv(int v, int mx);
    return (v > mx) ? mx : v;
  endfunction
  function automatic int stepv(int mx);
    return (mx >= 100) ? 1 : 100 - mx;
  endfunction
  function automatic int exp_lin(int v, int mx);
    int c = clampv(v, mx);
    return (c / stepv(mx)) * stepv(mx);
  endfunction
  function automatic int exp_nl(int v, int mx);
    int c = clampv(v, mx);
    int p = 0;
    for (int k = 1; k <= c; k = k * 2) p = k;
    return p;
  endfunction

  task automatic read_cls(input int cls, input string req, input int exp);
    rd_cls = 3'(cls);
    @(negedge clk);
    check(req, int'(rd_val), exp);
  endtask

  // Issue one request, check latency, result, clamp flag and stored value.
  task automatic run_req(input int cls, input int v, input bit nl, input int mx);
    int cyc = 0;
    int ev  = nl ? exp_nl(v, mx) : exp_lin(v, mx);
    int lat = nl ? 1 : clampv(v, mx) / stepv(mx) + 1;
    @(negedge clk);
    cfg_nonlin = nl; cfg_max = VW'(mx);
    req_cls = 3'(cls); req_val = VW'(v); req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    check(nl ? "R5 latency" : "R4 latency", cyc, lat);
    check(nl ? "R5 value" : "R3 value", int'(done_val), ev);
    check("R2 clamp flag", int'(done_clamp), (v > mx) ? 1 : 0);
    check("R8 busy low at done", int'(busy), 0);
    @(negedge clk);
    check("R8 done one cycle", int'(done), 0);
    read_cls(cls, "R6 stored value", ev);
  endtask

  task automatic t_reset;
    check("R1 busy after reset", int'(busy), 0);
    check("R1 done after reset", int'(done), 0);
    for (int c = 0; c < NCLS; c++) read_cls(c, "R1 class reset to 0", 0);
  endtask

  task automatic t_linear;
    run_req(1, 12, 1'b0, 90);   // step 10 -> 10
    run_req(2, 0, 1'b0, 90);    // zero
    run_req(3, 57, 1'b0, 75);   // step 25 -> 50
    run_req(4, 120, 1'b0, 90);  // clamp to 90, multiple of 10
    run_req(5, 37, 1'b0, 100);  // step 1
    run_req(0, 9, 1'b0, 90);    // class 0, below step
  endtask

  task automatic t_nonlin;
    run_req(1, 12, 1'b1, 90);   // -> 8
    run_req(2, 0, 1'b1, 90);    // -> 0
    run_req(3, 127, 1'b1, 127); // -> 64
    run_req(4, 100, 1'b1, 40);  // clamp 40 -> 32
    run_req(6, 1, 1'b1, 90);    // -> 1
  endtask

  task automatic t_busy_drop;
    int cyc = 0;
    read_cls(7, "R7 precondition", 0);
    @(negedge clk);
    cfg_nonlin = 1'b0; cfg_max = VW'(99);
    req_cls = 3'd6; req_val = VW'(120); req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 busy after accept", int'(busy), 1);
    @(negedge clk);
    req_cls = 3'd7; req_val = VW'(64); cfg_nonlin = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    check("R7 first result kept", int'(done_val), 99);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R7 no extra done", int'(done), 0);
    end
    read_cls(7, "R7 dropped request left class", 0);
    read_cls(6, "R6 long run stored", 99);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_linear;
    t_nonlin;
    t_busy_drop;
    finished = 1'b1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule